// File: doc/BRIEF.md
# Local Interrupt Vector Table Unit

This block belongs to a single processor's interrupt controller. It holds the table entries that describe two local interrupt pins, a spurious-interrupt register with the unit's software enable, and an error-status register. Software reaches all of them through a 32-bit register port, addressed by a 12-bit offset, that has no wait states. Reads are combinational from the offset, and writes take effect at the clock edge on which they are presented.

Each pin is synchronized, then corrected for its programmed polarity. It is then detected as an edge, or as a level where the entry asks for level sensing. A pin that is unmasked and enabled turns into a typed delivery request, one cycle wide, carrying the entry's vector and delivery kind. The unit issues at most one request per cycle, and the lower pin has priority. Requests that would carry a reserved vector, and accesses to offsets that do not exist, are recorded in the error-status register. Software collects them by writing that register.

Top module: `lvt_unit`

## Requirements
- R1: After reset both pin entries read 0x0001_0000 (masked, all other fields zero), the spurious register reads 0x0000_00FF (vector 0xFF, unit disabled), the error-status register reads 0 and req_valid is low.
- R2: The entry for pin i sits at offset 0x350 + 0x10*i. It keeps the vector in bits 7:0, the delivery mode in bits 10:8, active-low polarity in bit 13, level sensing in bit 15 and the mask in bit 16. All other bits read 0, so writing 0xFFFF_FFFF reads back 0x0001_A7FF.
- R3: The spurious register at offset 0x0F0 holds an 8-bit vector in bits 7:0 and the unit enable in bit 8. With the default configuration, vector bits 2:0 always read 1: writing 0x1A0 reads 0x1A7, and writing 0 reads 0x7.
- R4: On an unmasked, enabled, edge-sensed pin, an inactive-to-active transition yields exactly one request. req_valid is high for one cycle after the fourth rising clock edge that follows the pin change. req_kind carries the entry's mode, req_vector its vector and req_pin the pin index. The return to inactive yields no request.
- R5: With the polarity bit set, a high-to-low pin transition is the active edge and a low-to-high transition yields nothing.
- R6: The level bit is honoured only when the mode is fixed (000). A fixed, level-sensed pin then requests on every cycle its input is active, with the same four-edge lag. For any other mode the level bit is ignored and the pin behaves as edge sensed.
- R7: A pin whose mask bit is set, or any pin while the enable bit is clear, generates no request.
- R8: When both pins become active in the same cycle, pin 0 is issued first and pin 1 on the next cycle.
- R9: A fixed-mode request whose vector is below 0x20 is not issued. Instead it sets the latched illegal-vector flag, which is bit 0 of the error-status register.
- R10: A read or write at any offset other than 0x0F0, 0x280, 0x350 or 0x360 sets the latched bad-address flag, which is bit 1 of the error-status register. Such a read returns 0 and such a write changes no register.
- R11: The error-status register at offset 0x280 shows latched flags only after a write to it. That write copies the latched flags to the visible value and clears the latch. Flags raised in the same cycle as the write stay latched.
- R12: The delivery mode codes are 000 fixed, 010 SMI, 100 NMI, 101 INIT and 111 external interrupt. The codes 001, 011 and 110 are reserved and produce no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_en | input | 1 | Register access strobe |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 12 | Register offset |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, combinational from acc_addr |
| pin_in | input | 2 | Local interrupt pins, asynchronous |
| req_valid | output | 1 | Delivery request, one cycle per event |
| req_kind | output | 3 | Delivery mode of the request |
| req_vector | output | 8 | Vector of the request |
| req_pin | output | 1 | Index of the pin that raised the request |

## Verification
A pending flag that fails to clear shows up as a second request one cycle after the first, at the fourth and fifth edges after the pin change. A pending flag that never sets shows up as a missing request at the fourth edge. A sync chain of the wrong length moves that edge, so the bench checks the exact cycle and not just that a request appears at some point. Wrong error bookkeeping stays hidden until software writes the error-status register: a flag that is lost, or shown too early, is exposed on the read that follows that write.

// File: rtl/lvt_pkg.sv
`timescale 1ns/1ps
package lvt_pkg;

  localparam logic [11:0] SPUR_OFS   = 12'h0F0;
  localparam logic [11:0] ESR_OFS    = 12'h280;
  localparam logic [11:0] ENT_BASE   = 12'h350;
  localparam logic [11:0] ENT_STRIDE = 12'h010;

  localparam logic [2:0] DM_FIXED  = 3'b000;
  localparam logic [2:0] DM_SMI    = 3'b010;
  localparam logic [2:0] DM_NMI    = 3'b100;
  localparam logic [2:0] DM_INIT   = 3'b101;
  localparam logic [2:0] DM_EXTINT = 3'b111;

  // Stored fields of one pin entry (word bits 16, 15, 13, 10:8, 7:0)
  typedef struct packed {
    logic       mask;
    logic       lvl;
    logic       act_low;
    logic [2:0] mode;
    logic [7:0] vec;
  } lvt_ent_t;

  localparam lvt_ent_t ENT_RESET = '{mask: 1'b1, lvl: 1'b0, act_low: 1'b0,
                                     mode: 3'b000, vec: 8'h00};

  function automatic logic mode_legal(input logic [2:0] m);
    return (m == DM_FIXED) || (m == DM_SMI) || (m == DM_NMI) ||
           (m == DM_INIT)  || (m == DM_EXTINT);
  endfunction

  function automatic logic [31:0] ent_to_word(input lvt_ent_t e);
    return {15'd0, e.mask, e.lvl, 1'b0, e.act_low, 2'b00, e.mode, e.vec};
  endfunction

  function automatic lvt_ent_t word_to_ent(input logic [31:0] w);
    lvt_ent_t e;
    e.mask    = w[16];
    e.lvl     = w[15];
    e.act_low = w[13];
    e.mode    = w[10:8];
    e.vec     = w[7:0];
    return e;
  endfunction

endpackage

// File: rtl/lvt_regs.sv
`timescale 1ns/1ps
module lvt_regs
  import lvt_pkg::*;
#(
  parameter int NUM_PINS = 2,
  parameter bit HW_LOW3  = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    acc_en,
  input  logic                    acc_wr,
  input  logic [11:0]             acc_addr,
  input  logic [31:0]             acc_wdata,
  output logic [31:0]             acc_rdata,
  input  logic                    illvec_evt,
  output lvt_ent_t [NUM_PINS-1:0] ent_q,
  output logic                    sp_en_q,
  output logic [1:0]              err_lat_q,
  output logic [1:0]              esr_vis_q
);

  logic [NUM_PINS-1:0] ent_hit;
  logic                sp_hit, esr_hit, any_hit, bad_addr, esr_wr;
  logic [7:0]          sp_vec_q, sp_vec_d, sp_vec_rd;
  logic                sp_en_d;
  logic [1:0]          err_new, err_lat_d, esr_vis_d;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PINS; gi++) begin : g_ent
      localparam logic [11:0] OFS = 12'(ENT_BASE + ENT_STRIDE * gi);
      lvt_ent_t ent_d;
      assign ent_hit[gi] = (acc_addr == OFS);
      always_comb begin
        ent_d = ent_q[gi];
        if (acc_en && acc_wr && ent_hit[gi]) ent_d = word_to_ent(acc_wdata);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ent_q[gi] <= ENT_RESET;
        else        ent_q[gi] <= ent_d;
      end
    end
    if (HW_LOW3) begin : g_low3
      assign sp_vec_rd = {sp_vec_q[7:3], 3'b111};
    end else begin : g_full
      assign sp_vec_rd = sp_vec_q;
    end
  endgenerate

  assign sp_hit   = (acc_addr == SPUR_OFS);
  assign esr_hit  = (acc_addr == ESR_OFS);
  assign any_hit  = sp_hit | esr_hit | (|ent_hit);
  assign bad_addr = acc_en & ~any_hit;
  assign esr_wr   = acc_en & acc_wr & esr_hit;
  assign err_new  = {bad_addr, illvec_evt};

  always_comb begin
    sp_vec_d = sp_vec_q;
    sp_en_d  = sp_en_q;
    if (acc_en && acc_wr && sp_hit) begin
      sp_vec_d = acc_wdata[7:0];
      sp_en_d  = acc_wdata[8];
    end
    esr_vis_d = esr_wr ? err_lat_q : esr_vis_q;
    err_lat_d = esr_wr ? err_new : (err_lat_q | err_new);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_vec_q  <= 8'hFF;
      sp_en_q   <= 1'b0;
      esr_vis_q <= 2'b00;
      err_lat_q <= 2'b00;
    end else begin
      sp_vec_q  <= sp_vec_d;
      sp_en_q   <= sp_en_d;
      esr_vis_q <= esr_vis_d;
      err_lat_q <= err_lat_d;
    end
  end

  always_comb begin
    acc_rdata = 32'd0;
    if (sp_hit)  acc_rdata = {23'd0, sp_en_q, sp_vec_rd};
    if (esr_hit) acc_rdata = {30'd0, esr_vis_q};
    for (int i = 0; i < NUM_PINS; i++)
      if (ent_hit[i]) acc_rdata = ent_to_word(ent_q[i]);
  end

endmodule

// File: rtl/lvt_pin_det.sv
`timescale 1ns/1ps
module lvt_pin_det #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic act_low,
  output logic active,
  output logic edge_evt
);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], pin};
    active = sync_q[SYNC_STAGES-1] ^ act_low;
    edge_evt = active & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= active;
    end
  end

endmodule

// File: rtl/lvt_arb.sv
`timescale 1ns/1ps
module lvt_arb
  import lvt_pkg::*;
#(
  parameter int NUM_PINS = 2,
  localparam int IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  lvt_ent_t [NUM_PINS-1:0] ent,
  input  logic [NUM_PINS-1:0]     allow,
  input  logic [NUM_PINS-1:0]     lvl_mode,
  input  logic [NUM_PINS-1:0]     active,
  input  logic [NUM_PINS-1:0]     edge_evt,
  output logic                    illvec_evt,
  output logic                    req_valid,
  output logic [2:0]              req_kind,
  output logic [7:0]              req_vector,
  output logic [IDX_W-1:0]        req_pin
);

  logic [NUM_PINS-1:0] pend_q, pend_d, cand, grant;
  logic                found, issue, low_vec, is_fixed;
  logic [IDX_W-1:0]    idx;

  assign cand = pend_q & allow;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (cand[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
    grant    = found ? (NUM_PINS'(1) << idx) : '0;
    is_fixed = (ent[idx].mode == DM_FIXED);
    low_vec  = (ent[idx].vec[7:5] == 3'b000);
    illvec_evt = found & is_fixed & low_vec;
    issue    = found & mode_legal(ent[idx].mode) & ~(is_fixed & low_vec);
    for (int i = 0; i < NUM_PINS; i++) begin
      if (!allow[i])        pend_d[i] = 1'b0;
      else if (lvl_mode[i]) pend_d[i] = active[i];
      else                  pend_d[i] = (pend_q[i] & ~grant[i]) | edge_evt[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= '0;
      req_valid  <= 1'b0;
      req_kind   <= 3'b000;
      req_vector <= 8'h00;
      req_pin    <= '0;
    end else begin
      pend_q    <= pend_d;
      req_valid <= issue;
      if (issue) begin
        req_kind   <= ent[idx].mode;
        req_vector <= ent[idx].vec;
        req_pin    <= idx;
      end
    end
  end

endmodule

// File: rtl/lvt_unit.sv
`timescale 1ns/1ps
module lvt_unit
  import lvt_pkg::*;
#(
  parameter int NUM_PINS    = 2,
  parameter int SYNC_STAGES = 2,
  parameter bit HW_LOW3     = 1'b1,
  localparam int IDX_W      = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_en,
  input  logic                acc_wr,
  input  logic [11:0]         acc_addr,
  input  logic [31:0]         acc_wdata,
  output logic [31:0]         acc_rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic                req_valid,
  output logic [2:0]          req_kind,
  output logic [7:0]          req_vector,
  output logic [IDX_W-1:0]    req_pin
);

  logic                    rst_meta_q, rst_s_n;
  lvt_ent_t [NUM_PINS-1:0] ent_q;
  logic                    sp_en_q, illvec_evt;
  logic [1:0]              err_lat_q, esr_vis_q;
  logic [NUM_PINS-1:0]     allow, lvl_mode, active, edge_evt, ent_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s_n    <= rst_meta_q;
    end
  end

  lvt_regs #(.NUM_PINS(NUM_PINS), .HW_LOW3(HW_LOW3)) u_regs (
    .clk(clk), .rst_n(rst_s_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .illvec_evt(illvec_evt), .ent_q(ent_q), .sp_en_q(sp_en_q),
    .err_lat_q(err_lat_q), .esr_vis_q(esr_vis_q)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NUM_PINS; gi++) begin : g_pin
      assign ent_mask[gi] = ent_q[gi].mask;
      assign allow[gi]    = sp_en_q & ~ent_q[gi].mask;
      assign lvl_mode[gi] = ent_q[gi].lvl & (ent_q[gi].mode == DM_FIXED);
      lvt_pin_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
        .clk(clk), .rst_n(rst_s_n), .pin(pin_in[gi]),
        .act_low(ent_q[gi].act_low), .active(active[gi]),
        .edge_evt(edge_evt[gi])
      );
    end
  endgenerate

  lvt_arb #(.NUM_PINS(NUM_PINS)) u_arb (
    .clk(clk), .rst_n(rst_s_n), .ent(ent_q), .allow(allow),
    .lvl_mode(lvl_mode), .active(active), .edge_evt(edge_evt),
    .illvec_evt(illvec_evt), .req_valid(req_valid), .req_kind(req_kind),
    .req_vector(req_vector), .req_pin(req_pin)
  );

endmodule

// File: rtl/lvt_unit_chk.sv
`timescale 1ns/1ps
module lvt_unit_chk
  import lvt_pkg::*;
#(
  parameter int NUM_PINS = 2,
  parameter int IDX_W    = 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                acc_en,
  input logic                acc_wr,
  input logic [11:0]         acc_addr,
  input logic                req_valid,
  input logic [2:0]          req_kind,
  input logic [7:0]          req_vector,
  input logic [IDX_W-1:0]    req_pin,
  input logic                sp_en,
  input logic [NUM_PINS-1:0] ent_mask,
  input logic [1:0]          err_lat,
  input logic [1:0]          esr_vis
);

  logic addr_known;
  always_comb begin
    addr_known = (acc_addr == SPUR_OFS) || (acc_addr == ESR_OFS);
    for (int i = 0; i < NUM_PINS; i++)
      if (acc_addr == 12'(ENT_BASE + ENT_STRIDE * i)) addr_known = 1'b1;
  end

  assert_kind_legal_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> mode_legal(req_kind));

  assert_no_low_vector_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == DM_FIXED) |-> (req_vector >= 8'h20));

  assert_enable_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> $past(sp_en));

  assert_mask_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (($past(ent_mask) & (NUM_PINS'(1) << req_pin)) == '0));

  assert_bad_addr_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !addr_known) |=> err_lat[1]);

  assert_esr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_en && acc_wr && acc_addr == ESR_OFS) |=> $stable(esr_vis));

endmodule

bind lvt_unit lvt_unit_chk #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst_n(rst_s_n), .acc_en(acc_en), .acc_wr(acc_wr),
  .acc_addr(acc_addr), .req_valid(req_valid), .req_kind(req_kind),
  .req_vector(req_vector), .req_pin(req_pin), .sp_en(sp_en_q),
  .ent_mask(ent_mask), .err_lat(err_lat_q), .esr_vis(esr_vis_q)
);

// File: tb/lvt_unit_tb_top.sv
`timescale 1ns/1ps
module lvt_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_en, acc_wr;
  logic [11:0] acc_addr;
  logic [31:0] acc_wdata, acc_rdata;
  logic [1:0]  pin_in;
  logic        req_valid;
  logic [2:0]  req_kind;
  logic [7:0]  req_vector;
  logic [0:0]  req_pin;

  int n_chk = 0;
  int n_fail = 0;
  int req_cnt = 0;
  logic [2:0] last_kind;
  logic [7:0] last_vec;
  logic       last_pin;

  always #2 clk = ~clk;

  lvt_unit dut_i (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .pin_in(pin_in), .req_valid(req_valid), .req_kind(req_kind),
    .req_vector(req_vector), .req_pin(req_pin)
  );

  always @(negedge clk) begin
    if (rst_n && req_valid) begin
      req_cnt   = req_cnt + 1;
      last_kind = req_kind;
      last_vec  = req_vector;
      last_pin  = req_pin[0];
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b0; acc_addr = a;
    #1 d = acc_rdata;
    @(negedge clk);
    acc_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pin(input int i, input logic v);
    @(negedge clk);
    pin_in[i] = v;
  endtask

  task automatic esr_clear();
    bus_wr(12'h280, 32'd0);
    bus_wr(12'h280, 32'd0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 req_valid", {31'd0, req_valid}, 32'd0);
    bus_rd(12'h350, d); check("R1 entry0", d, 32'h0001_0000);
    bus_rd(12'h360, d); check("R1 entry1", d, 32'h0001_0000);
    bus_rd(12'h0F0, d); check("R1 spurious", d, 32'h0000_00FF);
    bus_rd(12'h280, d); check("R1 esr", d, 32'd0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    bus_wr(12'h360, 32'hFFFF_FFFF);
    bus_rd(12'h360, d); check("R2 entry1 implemented bits", d, 32'h0001_A7FF);
    bus_wr(12'h360, 32'h0001_0000);
    bus_wr(12'h350, 32'h0000_2A5C);
    bus_rd(12'h350, d); check("R2 entry0 fields", d, 32'h0000_225C);
    bus_wr(12'h350, 32'h0001_0000);
  endtask

  task automatic t_spur();
    logic [31:0] d;
    bus_wr(12'h0F0, 32'h0000_01A0);
    bus_rd(12'h0F0, d); check("R3 low bits forced", d, 32'h0000_01A7);
    bus_wr(12'h0F0, 32'h0000_0000);
    bus_rd(12'h0F0, d); check("R3 zero write", d, 32'h0000_0007);
    bus_wr(12'h0F0, 32'h0000_01FF);
  endtask

  task automatic t_edge();
    bus_wr(12'h350, 32'h0000_0440);
    idle(2);
    req_cnt = 0;
    @(negedge clk); pin_in[0] = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); check("R4 no request before fourth edge", {31'd0, req_valid}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    check("R4 request at fourth edge", {31'd0, req_valid}, 32'd1);
    check("R4 kind", {29'd0, req_kind}, 32'd4);
    check("R4 vector", {24'd0, req_vector}, 32'h40);
    check("R4 pin", {31'd0, req_pin}, 32'd0);
    @(posedge clk);
    @(negedge clk); check("R4 single cycle", {31'd0, req_valid}, 32'd0);
    idle(3);
    set_pin(0, 1'b0);
    idle(8);
    check("R4 one request per transition", req_cnt, 32'd1);
  endtask

  task automatic t_polarity();
    set_pin(1, 1'b1);
    idle(4);
    bus_wr(12'h360, 32'h0000_2755);
    idle(4);
    req_cnt = 0;
    set_pin(1, 1'b0);
    idle(8);
    check("R5 falling edge count", req_cnt, 32'd1);
    check("R5 kind", {29'd0, last_kind}, 32'd7);
    check("R5 vector", {24'd0, last_vec}, 32'h55);
    check("R5 pin", {31'd0, last_pin}, 32'd1);
    set_pin(1, 1'b1);
    idle(8);
    check("R5 rising edge ignored", req_cnt, 32'd1);
    bus_wr(12'h360, 32'h0001_0000);
    set_pin(1, 1'b0);
    idle(4);
  endtask

  task automatic t_trigger();
    bus_wr(12'h350, 32'h0000_8060);
    idle(2);
    req_cnt = 0;
    set_pin(0, 1'b1);
    idle(10);
    pin_in[0] = 1'b0;
    idle(8);
    check("R6 level fixed repeats", req_cnt, 32'd10);
    check("R6 level kind", {29'd0, last_kind}, 32'd0);
    bus_wr(12'h350, 32'h0000_8440);
    idle(2);
    req_cnt = 0;
    set_pin(0, 1'b1);
    idle(10);
    pin_in[0] = 1'b0;
    idle(8);
    check("R6 level bit ignored for NMI", req_cnt, 32'd1);
  endtask

  task automatic t_mask();
    bus_wr(12'h350, 32'h0001_0440);
    req_cnt = 0;
    set_pin(0, 1'b1); idle(6); set_pin(0, 1'b0); idle(6);
    check("R7 masked pin", req_cnt, 32'd0);
    bus_wr(12'h350, 32'h0000_0440);
    bus_wr(12'h0F0, 32'h0000_00FF);
    set_pin(0, 1'b1); idle(6); set_pin(0, 1'b0); idle(6);
    check("R7 unit disabled", req_cnt, 32'd0);
    bus_wr(12'h0F0, 32'h0000_01FF);
    idle(2);
  endtask

  task automatic t_both();
    bus_wr(12'h350, 32'h0000_0440);
    bus_wr(12'h360, 32'h0000_0533);
    idle(4);
    req_cnt = 0;
    @(negedge clk); pin_in = 2'b11;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R8 first pin0", {31'd0, req_valid}, 32'd1);
    check("R8 first pin index", {31'd0, req_pin}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    check("R8 second valid", {31'd0, req_valid}, 32'd1);
    check("R8 second pin index", {31'd0, req_pin}, 32'd1);
    check("R8 second kind", {29'd0, req_kind}, 32'd5);
    idle(4);
    pin_in = 2'b00;
    idle(8);
    check("R8 total", req_cnt, 32'd2);
    bus_wr(12'h360, 32'h0001_0000);
  endtask

  task automatic t_illvec();
    logic [31:0] d;
    esr_clear();
    bus_wr(12'h350, 32'h0000_0010);
    idle(2);
    req_cnt = 0;
    set_pin(0, 1'b1); idle(6); set_pin(0, 1'b0); idle(6);
    check("R9 low vector suppressed", req_cnt, 32'd0);
    bus_rd(12'h280, d); check("R11 esr hidden before write", d, 32'd0);
    bus_wr(12'h280, 32'd0);
    bus_rd(12'h280, d); check("R9 illegal vector flag", d, 32'h1);
    bus_wr(12'h280, 32'd0);
    bus_rd(12'h280, d); check("R11 latch cleared", d, 32'd0);
  endtask

  task automatic t_badaddr();
    logic [31:0] d;
    esr_clear();
    bus_wr(12'h350, 32'h0000_0440);
    bus_rd(12'h300, d); check("R10 bad read returns zero", d, 32'd0);
    bus_wr(12'h354, 32'hFFFF_FFFF);
    bus_rd(12'h350, d); check("R10 bad write no effect", d, 32'h0000_0440);
    bus_rd(12'h280, d); check("R11 esr unchanged without write", d, 32'd0);
    bus_wr(12'h280, 32'd0);
    bus_rd(12'h280, d); check("R10 bad address flag", d, 32'h2);
  endtask

  task automatic t_modes();
    for (int m = 0; m < 8; m++) begin
      logic exp_ok;
      exp_ok = (m == 0) || (m == 2) || (m == 4) || (m == 5) || (m == 7);
      bus_wr(12'h350, {21'd0, 3'(m), 8'h80});
      idle(2);
      req_cnt = 0;
      set_pin(0, 1'b1); idle(6); set_pin(0, 1'b0); idle(6);
      check($sformatf("R12 mode %0d count", m), req_cnt, exp_ok ? 32'd1 : 32'd0);
      if (exp_ok) check($sformatf("R12 mode %0d kind", m), {29'd0, last_kind}, 32'(m));
    end
  endtask

  initial begin
    acc_en = 1'b0; acc_wr = 1'b0; acc_addr = '0; acc_wdata = '0;
    pin_in = 2'b00;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_regs();
    t_spur();
    t_edge();
    t_polarity();
    t_trigger();
    t_mask();
    t_both();
    t_illvec();
    t_badaddr();
    t_modes();
    report();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

endmodule